// File: doc/BRIEF.md
# Dual-Input Delay with Timed Logic

This block delays two single-bit signals by whole clock cycles and drives four outputs from them. Each input feeds two delay paths of its own: a short path that gives a plain delayed copy, and a long path that feeds a two-input logic stage. The two long-path copies are combined by a function fixed at build time. One logic output offers AND-type functions, including a one-sided "half-XOR" that marks the interval between the two long edges. The other offers OR-type functions. Any output can be inverted by a static mask.

All delays, function choices and the inversion mask are parameters. A short delay above the short-path limit is not built as a separate line. That output then taps the long line of the same input instead. Rising and falling edges are delayed equally, so pulse widths are preserved. The output registers form the last stage of every path, so the delay seen at a port equals the configured cycle count exactly.

Top module: `twin_delay_logic`

## Requirements
- R1: `tap_a` equals `in_a` as sampled D1 rising clock edges earlier, and `tap_b` equals `in_b` as sampled D2 edges earlier, when D1 and D2 are in 1..SHORT_MAX and the inversion bit is clear.
- R2: If D1 exceeds SHORT_MAX, `tap_a` uses delay D3 instead of D1. If D2 exceeds SHORT_MAX, `tap_b` uses delay D4 instead of D2.
- R3: With a = `in_a` delayed D3 and b = `in_b` delayed D4, `mix_lo` follows FN_LO. The codes are 0 = a, 1 = a AND b, 2 = NOT(a AND b), 3 = half-XOR (a AND NOT b), and 4 = NOT half-XOR. Codes 5 to 7 give a.
- R4: With the same a and b, `mix_hi` follows FN_HI. The codes are 0 = b, 1 = a OR b, 2 = NOT(a OR b), 3 = a XOR b, and 4 = NOT(a XOR b). Codes 5 to 7 give b.
- R5: INV bit 0 inverts `tap_a`, bit 1 inverts `tap_b`, bit 2 inverts `mix_lo` and bit 3 inverts `mix_hi`. Inversion is applied after the function.
- R6: Rising and falling edges take the same delay, so an input pulse of W cycles gives an output pulse of W cycles.
- R7: A synchronous active-high `rst` clears all delay history. The input value at a reset edge is treated as 0. After a reset edge, each output shows its function of all-zero inputs, with inversion applied. It keeps showing the zero history until fresh input has travelled the full delay.
- R8: With FN_LO = 3 and D3 < D4, if both inputs rise together, `mix_lo` is high for exactly D4 − D3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | First input, feeds the D1 and D3 paths |
| in_b | input | 1 | Second input, feeds the D2 and D4 paths |
| tap_a | output | 1 | Delayed copy of `in_a` (D1, or D3 when shared) |
| tap_b | output | 1 | Delayed copy of `in_b` (D2, or D4 when shared) |
| mix_lo | output | 1 | AND-family function of the long copies |
| mix_hi | output | 1 | OR-family function of the long copies |

## Verification
The bench runs six configurations side by side. Together they cover the limit value of the short delay, delays above that limit, delays of one cycle, unequal long delays, every function code including unused ones, and several inversion masks. A design that lost a cycle through its output register, or that added one, would be off by one edge on every path. A design that did not redirect an over-limit short delay would show the wrong delay on the shared output. A design that took the half-XOR operands in the wrong order would pulse on the falling pair and miss the window of D4 − D3 cycles. A design that reset its outputs to plain zero under inversion, or that let an input seen during reset leak into the history, would differ in the first cycles after each reset.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // AND-family selector for the low logic output
    typedef enum logic [2:0] {
        LO_PASS  = 3'd0,
        LO_AND   = 3'd1,
        LO_NAND  = 3'd2,
        LO_HXOR  = 3'd3,
        LO_HXNOR = 3'd4
    } lo_fn_e;

    // OR-family selector for the high logic output
    typedef enum logic [2:0] {
        HI_PASS = 3'd0,
        HI_OR   = 3'd1,
        HI_NOR  = 3'd2,
        HI_XOR  = 3'd3,
        HI_XNOR = 3'd4
    } hi_fn_e;

    typedef struct packed {
        logic mix_hi;
        logic mix_lo;
        logic tap_b;
        logic tap_a;
    } out_s;

    function automatic logic lo_eval(input logic [2:0] sel, input logic a, input logic b);
        case (sel)
            LO_AND:   return a & b;
            LO_NAND:  return ~(a & b);
            LO_HXOR:  return a & ~b;
            LO_HXNOR: return ~a | b;
            default:  return a;
        endcase
    endfunction

    function automatic logic hi_eval(input logic [2:0] sel, input logic a, input logic b);
        case (sel)
            HI_OR:   return a | b;
            HI_NOR:  return ~(a | b);
            HI_XOR:  return a ^ b;
            HI_XNOR: return ~(a ^ b);
            default: return b;
        endcase
    endfunction

endpackage

// File: rtl/tdl_shift_line.sv
// Shift register of STAGES cells; the output register of the top adds the last stage.
module tdl_shift_line #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic tap
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign tap = sr_q[STAGES-1];
endmodule

// File: rtl/tdl_mix_unit.sv
// Combinational function stage applied to the two long-path taps.
module tdl_mix_unit
    import tdl_pkg::*;
#(
    parameter logic [2:0] FN_LO = 3'd0,
    parameter logic [2:0] FN_HI = 3'd0
) (
    input  logic a,
    input  logic b,
    output logic lo,
    output logic hi
);
    always_comb begin
        lo = lo_eval(FN_LO, a, b);
        hi = hi_eval(FN_HI, a, b);
    end
endmodule

// File: rtl/twin_delay_logic.sv
module twin_delay_logic
    import tdl_pkg::*;
#(
    parameter int         SHORT_MAX = 10,
    parameter int         D1        = 3,
    parameter int         D2        = 5,
    parameter int         D3        = 7,
    parameter int         D4        = 12,
    parameter logic [2:0] FN_LO     = 3'd3,
    parameter logic [2:0] FN_HI     = 3'd3,
    parameter logic [3:0] INV       = 4'b0000
) (
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    output logic tap_a,
    output logic tap_b,
    output logic mix_lo,
    output logic mix_hi
);
    localparam bit SHARE_A = (D1 > SHORT_MAX);
    localparam bit SHARE_B = (D2 > SHORT_MAX);

    localparam out_s RST_V = '{
        mix_hi: hi_eval(FN_HI, 1'b0, 1'b0) ^ INV[3],
        mix_lo: lo_eval(FN_LO, 1'b0, 1'b0) ^ INV[2],
        tap_b:  INV[1],
        tap_a:  INV[0]
    };

    logic [1:0] src;
    logic [1:0] long_pre;
    logic [1:0] short_pre;
    logic       fn_lo, fn_hi;
    out_s       out_d, out_q;

    assign src = {in_b, in_a};

    // Long paths: the value that enters the output register after DEP-1 cells
    for (genvar p = 0; p < 2; p++) begin : g_long
        localparam int DEP = (p == 0) ? D3 : D4;
        if (DEP <= 1) begin : g_direct
            assign long_pre[p] = src[p];
        end else begin : g_line
            tdl_shift_line #(.STAGES(DEP - 1)) u_line (
                .clk (clk),
                .rst (rst),
                .din (src[p]),
                .tap (long_pre[p])
            );
        end
    end

    // Short paths: own line, or the long line of the same input when over the limit
    for (genvar p = 0; p < 2; p++) begin : g_short
        localparam int DEP = (p == 0) ? D1 : D2;
        localparam bit SHR = (p == 0) ? SHARE_A : SHARE_B;
        if (SHR) begin : g_shared
            assign short_pre[p] = long_pre[p];
        end else if (DEP <= 1) begin : g_direct
            assign short_pre[p] = src[p];
        end else begin : g_line
            tdl_shift_line #(.STAGES(DEP - 1)) u_line (
                .clk (clk),
                .rst (rst),
                .din (src[p]),
                .tap (short_pre[p])
            );
        end
    end

    tdl_mix_unit #(.FN_LO(FN_LO), .FN_HI(FN_HI)) u_mix (
        .a  (long_pre[0]),
        .b  (long_pre[1]),
        .lo (fn_lo),
        .hi (fn_hi)
    );

    always_comb begin
        out_d        = out_q;
        out_d.tap_a  = short_pre[0] ^ INV[0];
        out_d.tap_b  = short_pre[1] ^ INV[1];
        out_d.mix_lo = fn_lo ^ INV[2];
        out_d.mix_hi = fn_hi ^ INV[3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= RST_V;
        end else begin
            out_q <= out_d;
        end
    end

    assign tap_a  = out_q.tap_a;
    assign tap_b  = out_q.tap_b;
    assign mix_lo = out_q.mix_lo;
    assign mix_hi = out_q.mix_hi;
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
    parameter int         SHORT_MAX = 10,
    parameter int         D1        = 3,
    parameter int         D2        = 5,
    parameter int         D3        = 7,
    parameter int         D4        = 12,
    parameter logic [2:0] FN_LO     = 3'd3,
    parameter logic [2:0] FN_HI     = 3'd3,
    parameter logic [3:0] INV       = 4'b0000
) (
    input logic clk,
    input logic rst,
    input logic in_a,
    input logic in_b,
    input logic tap_a,
    input logic tap_b,
    input logic mix_lo,
    input logic mix_hi
);
    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Truth tables indexed by {a,b}
    function automatic logic [3:0] lo_tbl(input logic [2:0] s);
        case (s)
            3'd1:    return 4'b1000;
            3'd2:    return 4'b0111;
            3'd3:    return 4'b0100;
            3'd4:    return 4'b1011;
            default: return 4'b1100;
        endcase
    endfunction

    function automatic logic [3:0] hi_tbl(input logic [2:0] s);
        case (s)
            3'd1:    return 4'b1110;
            3'd2:    return 4'b0001;
            3'd3:    return 4'b0110;
            3'd4:    return 4'b1001;
            default: return 4'b1010;
        endcase
    endfunction

    localparam int         EA = (D1 > SHORT_MAX) ? D3 : D1;
    localparam int         EB = (D2 > SHORT_MAX) ? D4 : D2;
    localparam int         HW = imax(2, imax(imax(EA, EB), imax(D3, D4)));
    localparam logic [3:0] LT = lo_tbl(FN_LO);
    localparam logic [3:0] HT = hi_tbl(FN_HI);

    // Input history: bit i holds the input seen i+1 edges ago
    logic [HW-1:0] ha_q, hb_q;
    logic [1:0]    lidx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ha_q <= '0;
            hb_q <= '0;
        end else begin
            ha_q <= {ha_q[HW-2:0], in_a};
            hb_q <= {hb_q[HW-2:0], in_b};
        end
    end

    assign lidx = {ha_q[D3-1], hb_q[D4-1]};

    // R1 and R2 (effective delay), R5 (inversion)
    a_r1_tap_a_delay: assert property (@(posedge clk) disable iff (rst)
        tap_a == (ha_q[EA-1] ^ INV[0]));
    // R1 and R2 for the second input, R5
    a_r1_tap_b_delay: assert property (@(posedge clk) disable iff (rst)
        tap_b == (hb_q[EB-1] ^ INV[1]));
    // R3, R5
    a_r3_mix_lo_func: assert property (@(posedge clk) disable iff (rst)
        mix_lo == (LT[lidx] ^ INV[2]));
    // R4, R5
    a_r4_mix_hi_func: assert property (@(posedge clk) disable iff (rst)
        mix_hi == (HT[lidx] ^ INV[3]));
    // R7
    a_r7_reset_value: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ({mix_hi, mix_lo, tap_b, tap_a} ==
                        {HT[0] ^ INV[3], LT[0] ^ INV[2], INV[1], INV[0]}));
endmodule

bind twin_delay_logic tdl_checker #(
    .SHORT_MAX (SHORT_MAX),
    .D1        (D1),
    .D2        (D2),
    .D3        (D3),
    .D4        (D4),
    .FN_LO     (FN_LO),
    .FN_HI     (FN_HI),
    .INV       (INV)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .in_a   (in_a),
    .in_b   (in_b),
    .tap_a  (tap_a),
    .tap_b  (tap_b),
    .mix_lo (mix_lo),
    .mix_hi (mix_hi)
);

// File: tb/tb_twin_delay_logic.sv
`timescale 1ns/100ps
module tb_twin_delay_logic;
    localparam int NCFG      = 6;
    localparam int SHORT_MAX = 10;

    localparam int T_D1  [NCFG] = '{3, 12, 10, 1, 4, 2};
    localparam int T_D2  [NCFG] = '{5,  1, 11, 2, 6, 3};
    localparam int T_D3  [NCFG] = '{7,  9,  6, 1, 5, 8};
    localparam int T_D4  [NCFG] = '{12, 4, 11, 3, 2, 8};
    localparam int T_FL  [NCFG] = '{3,  2,  1, 4, 7, 0};
    localparam int T_FH  [NCFG] = '{3,  2,  1, 4, 0, 6};
    localparam int T_INV [NCFG] = '{0,  5, 10, 0, 15, 0};

    logic clk  = 1'b0;
    logic rst  = 1'b1;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic [3:0] y [NCFG];

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        logic [3:0] yy;
        twin_delay_logic #(
            .SHORT_MAX (SHORT_MAX),
            .D1        (T_D1[g]),
            .D2        (T_D2[g]),
            .D3        (T_D3[g]),
            .D4        (T_D4[g]),
            .FN_LO     (3'(T_FL[g])),
            .FN_HI     (3'(T_FH[g])),
            .INV       (4'(T_INV[g]))
        ) dut (
            .clk    (clk),
            .rst    (rst),
            .in_a   (in_a),
            .in_b   (in_b),
            .tap_a  (yy[0]),
            .tap_b  (yy[1]),
            .mix_lo (yy[2]),
            .mix_hi (yy[3])
        );
        assign y[g] = yy;
    end

    // Behavioural history: element 0 is the input seen at the latest edge
    bit ha[$];
    bit hb[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit win6   = 0;
    bit win8   = 0;
    int cnt6   = 0;
    int cnt8   = 0;
    logic [15:0] lf = 16'hACE1;

    always @(posedge clk) begin
        if (rst) begin
            ha.delete();
            hb.delete();
        end else begin
            ha.push_front(in_a);
            hb.push_front(in_b);
            if (ha.size() > 64) begin
                void'(ha.pop_back());
                void'(hb.pop_back());
            end
        end
    end

    function automatic bit hist_at(input bit q[$], input int n);
        if (n - 1 < q.size()) return q[n-1];
        return 1'b0;
    endfunction

    function automatic bit lo_ref(input int s, input bit a, input bit b);
        if (s == 1) return a && b;
        if (s == 2) return !(a && b);
        if (s == 3) return a && !b;
        if (s == 4) return !(a && !b);
        return a;
    endfunction

    function automatic bit hi_ref(input int s, input bit a, input bit b);
        if (s == 1) return a || b;
        if (s == 2) return !(a || b);
        if (s == 3) return a != b;
        if (s == 4) return a == b;
        return b;
    endfunction

    function automatic bit expect_bit(input int g, input int k);
        int e1 = (T_D1[g] > SHORT_MAX) ? T_D3[g] : T_D1[g];
        int e2 = (T_D2[g] > SHORT_MAX) ? T_D4[g] : T_D2[g];
        bit a  = hist_at(ha, T_D3[g]);
        bit b  = hist_at(hb, T_D4[g]);
        bit v;
        case (k)
            0:       v = hist_at(ha, e1);
            1:       v = hist_at(hb, e2);
            2:       v = lo_ref(T_FL[g], a, b);
            default: v = hi_ref(T_FH[g], a, b);
        endcase
        return v ^ bit'((T_INV[g] >> k) & 1);
    endfunction

    function automatic string tag_of(input int g, input int k);
        if (rst) return "R7";
        if (k == 0 && T_D1[g] > SHORT_MAX) return "R2";
        if (k == 1 && T_D2[g] > SHORT_MAX) return "R2";
        if (((T_INV[g] >> k) & 1) != 0) return "R5";
        if (k == 2) return "R3";
        if (k == 3) return "R4";
        return "R1";
    endfunction

    task automatic check_all();
        for (int g = 0; g < NCFG; g++) begin
            for (int k = 0; k < 4; k++) begin
                bit e = expect_bit(g, k);
                n_chk++;
                if (y[g][k] !== e) begin
                    n_fail++;
                    $display("FAIL %s cfg%0d out%0d: got %b expected %b",
                             tag_of(g, k), g, k, y[g][k], e);
                end
            end
        end
    endtask

    task automatic named_check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Compare at the falling edge, then drive the next inputs
    task automatic step(input bit a, input bit b, input bit r);
        @(negedge clk);
        check_all();
        if (win6 && y[0][0] === 1'b1) cnt6++;
        if (win8 && y[0][2] === 1'b1) cnt8++;
        in_a = a;
        in_b = b;
        rst  = r;
    endtask

    task automatic lfsr_adv();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        // R7: inputs held high during reset must not enter the history
        repeat (3) step(1'b1, 1'b1, 1'b1);
        repeat (20) step(1'b1, 1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0, 1'b0);

        // R8: both rise together; half-XOR window of cfg0 is D4-D3 = 5
        win8 = 1;
        repeat (40) step(1'b1, 1'b1, 1'b0);
        repeat (25) step(1'b0, 1'b0, 1'b0);
        win8 = 0;
        named_check("R8", cnt8, 5);

        // R6: a 40-cycle pulse on in_a keeps its width on tap_a of cfg0
        win6 = 1;
        repeat (40) step(1'b1, 1'b0, 1'b0);
        repeat (25) step(1'b0, 1'b0, 1'b0);
        win6 = 0;
        named_check("R6", cnt6, 40);

        // Fast random patterns
        for (int i = 0; i < 400; i++) begin
            lfsr_adv();
            step(lf[0], lf[5], 1'b0);
        end

        // Slow patterns with held levels
        for (int i = 0; i < 40; i++) begin
            lfsr_adv();
            repeat (3 + int'(lf[3:1])) step(lf[0], lf[7], 1'b0);
        end

        // R7: reset in mid-stream with active inputs
        for (int i = 0; i < 2; i++) begin
            lfsr_adv();
            step(lf[2], lf[9], 1'b1);
        end
        for (int i = 0; i < 200; i++) begin
            lfsr_adv();
            step(lf[4], lf[11], 1'b0);
        end
        step(1'b0, 1'b0, 1'b0);

        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            report();
            $finish;
        end
    end
endmodule